// File: doc/BRIEF.md
# Blitter command queue with run gate

This block sits between a host processor and a polygon or blit engine. The host pushes command words into a small storage queue. From the host's side it looks like a handful of registers: a control register, a write-only limit register, a loadable entry counter, a 4-bit status word, and a status alias that also bumps the counter when it is read. The engine pulls words one at a time over a valid/ready handshake. It reports back two levels: one says it is plotting, the other says it is using the shared data bus.

The entry counter runs separately from the storage that actually holds words. Pushes and alias reads raise it, and words handed to the engine lower it. Software may clear it, preload it, or compare it with a limit of its own choosing. Once the counter reaches that limit, the queue counts as maxed out. A host push that arrives then is thrown away and recorded in a sticky overflow bit.

The run-select control bit gates only the start of new work. A blit already running ends normally, and no further word is offered until software sets run select again. Software can therefore clear run select, wait for the bus-in-use status bit to read 0, change the engine setup outside this block, and then restart.

Top module: `blit_cmd_queue`

## Requirements
- R1: After reset the entry count, status word, control register and overflow bit are all 0, and no word is offered to the engine. The limit register resets to DEPTH.
- R2: An accepted host push stores the word at the tail and raises the count by 1. Status bit 0 reads 1 while at least one word is held in storage.
- R3: Status bit 2 reads 1 while count >= limit. A push made while bit 2 is set, or while storage holds DEPTH words, is discarded. The count does not change, and the overflow bit is set and stays set.
- R4: A word is offered (eng_valid = 1, eng_data = oldest word) only when control bit 3 (run select) is 1, eng_busy is 0 and storage is not empty. Words leave in the order they were pushed.
- R5: Each handshake (eng_valid and eng_ready both 1 at a clock edge) removes the oldest word and lowers the count by 1. An accepted push in the same cycle leaves the count unchanged.
- R6: A control write that changes bit 1 from 1 to 0 clears the count and the overflow bit, and leaves the stored words untouched.
- R7: A counter load (cnt_wr_en) sets the count to cnt_wr_data only while control bit 2 is 1. With bit 2 at 0 the load is ignored.
- R8: A pulse on stat_rd_inc raises the count by 1, on top of any push in the same cycle. It does not change storage.
- R9: Status bit 1 follows eng_busy and status bit 3 follows eng_bus_busy in the same cycle.
- R10: The count saturates. A decrement at 0 leaves it at 0, and an increment at all ones leaves it at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Host push strobe |
| cpu_wr_data | input | DATA_W | Command word to push |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 4 | Control value: bit3 run select, bit2 load enable, bit1 counter clear (on 1-to-0), bit0 spare |
| ctrl_rd | output | 4 | Control register readback |
| lim_wr_en | input | 1 | Limit register write strobe |
| lim_wr_data | input | CNT_W | New maximum entry count |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | CNT_W | Counter load value |
| stat_rd_inc | input | 1 | Status alias read, bumps the count |
| status | output | 4 | bit0 not empty, bit1 engine busy, bit2 at limit, bit3 bus in use |
| count | output | CNT_W | Entry counter |
| overflow | output | 1 | Sticky discarded-push flag |
| eng_valid | output | 1 | Word offered to engine |
| eng_data | output | DATA_W | Offered word |
| eng_ready | input | 1 | Engine takes the offered word |
| eng_busy | input | 1 | Engine is plotting |
| eng_bus_busy | input | 1 | Engine is using the data bus |

## Verification
Corrupt queue pointers or a wrong fill level show up on eng_data as a word out of order or missing, and on status bit 0, within one cycle of the next handshake. A faulty count path shows at the count port on the edge after the push, pop, alias read, load or clear that caused it. A wrong limit compare or a wrong discard decision shows in status bit 2 and the overflow bit one cycle later, and the bench confirms it by draining the queue and counting the words that come out.

// File: rtl/blit_cmd_queue.sv
module blit_cmd_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              ctrl_wr_en,
  input  logic [3:0]        ctrl_wr_data,
  output logic [3:0]        ctrl_rd,
  input  logic              lim_wr_en,
  input  logic [CNT_W-1:0]  lim_wr_data,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              stat_rd_inc,
  output logic [3:0]        status,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              eng_valid,
  output logic [DATA_W-1:0] eng_data,
  input  logic              eng_ready,
  input  logic              eng_busy,
  input  logic              eng_bus_busy
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = AW + 1;
  localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [FW-1:0]     fill;
  logic [3:0]        ctrl_q;
  logic [CNT_W-1:0]  limit_q;

  logic run_sel, load_en, at_max, not_empty;
  logic push_ok, drop, pop_fire, clr_evt;
  logic [CNT_W+1:0] cnt_sum;

  assign run_sel   = ctrl_q[3];
  assign load_en   = ctrl_q[2];
  assign not_empty = (fill != '0);
  assign at_max    = (count >= limit_q);

  assign push_ok  = cpu_wr_en && !at_max && (fill != FULL_LVL);
  assign drop     = cpu_wr_en && !push_ok;
  assign eng_valid = run_sel && !eng_busy && not_empty;
  assign eng_data  = mem[rd_ptr];
  assign pop_fire  = eng_valid && eng_ready;
  assign clr_evt   = ctrl_wr_en && ctrl_q[1] && !ctrl_wr_data[1];

  assign status  = {eng_bus_busy, at_max, eng_busy, not_empty};
  assign ctrl_rd = ctrl_q;

  assign cnt_sum = {2'b00, count}
                 + (CNT_W+2)'(push_ok) + (CNT_W+2)'(stat_rd_inc)
                 - (CNT_W+2)'(pop_fire);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= cpu_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_fire) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_fire})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= CNT_W'(DEPTH);
    end else begin
      if (ctrl_wr_en) ctrl_q  <= ctrl_wr_data;
      if (lim_wr_en)  limit_q <= lim_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr_evt) begin
      count <= '0;
    end else if (cnt_wr_en && load_en) begin
      count <= cnt_wr_data;
    end else if (cnt_sum[CNT_W+1]) begin
      count <= '0;
    end else if (cnt_sum[CNT_W]) begin
      count <= '1;
    end else begin
      count <= cnt_sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (clr_evt) overflow <= 1'b0;
    else if (drop)    overflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n) a_r3_fill_bound: assert (fill <= FULL_LVL);
  end

  a_r3_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en && status[2] && !clr_evt |=> overflow);

  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_evt |=> overflow);

  a_r6_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> count == '0);

  a_r5_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && !cpu_wr_en |=> fill == $past(fill) - 1'b1);

  a_r4_no_offer_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && !ctrl_wr_data[3] |=> !eng_valid);

endmodule

// File: tb/blit_cmd_queue_test.sv
module blit_cmd_queue_test;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic        cpu_wr_en = 0;
  logic [31:0] cpu_wr_data = 0;
  logic        ctrl_wr_en = 0;
  logic [3:0]  ctrl_wr_data = 0;
  logic [3:0]  ctrl_rd;
  logic        lim_wr_en = 0;
  logic [15:0] lim_wr_data = 0;
  logic        cnt_wr_en = 0;
  logic [15:0] cnt_wr_data = 0;
  logic        stat_rd_inc = 0;
  logic [3:0]  status;
  logic [15:0] count;
  logic        overflow;
  logic        eng_valid;
  logic [31:0] eng_data;
  logic        eng_ready = 0;
  logic        eng_busy = 0;
  logic        eng_bus_busy = 0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  blit_cmd_queue uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd(ctrl_rd),
    .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .stat_rd_inc(stat_rd_inc),
    .status(status), .count(count), .overflow(overflow),
    .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready),
    .eng_busy(eng_busy), .eng_bus_busy(eng_bus_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    cpu_wr_en = 1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 0;
  endtask

  task automatic wctrl(input logic [3:0] v);
    ctrl_wr_en = 1; ctrl_wr_data = v;
    @(negedge clk);
    ctrl_wr_en = 0;
  endtask

  task automatic wlim(input logic [15:0] v);
    lim_wr_en = 1; lim_wr_data = v;
    @(negedge clk);
    lim_wr_en = 0;
  endtask

  task automatic wcnt(input logic [15:0] v);
    cnt_wr_en = 1; cnt_wr_data = v;
    @(negedge clk);
    cnt_wr_en = 0;
  endtask

  task automatic bump();
    stat_rd_inc = 1;
    @(negedge clk);
    stat_rd_inc = 0;
  endtask

  task automatic clear_count();
    wctrl(4'b0010);
    wctrl(4'b0000);
  endtask

  task automatic t_reset();
    check("R1 count", 32'(count), 0);
    check("R1 status", 32'(status), 0);
    check("R1 ctrl", 32'(ctrl_rd), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 valid", 32'(eng_valid), 0);
  endtask

  task automatic t_push_run();
    push(32'hA1); push(32'hA2); push(32'hA3);
    check("R2 count", 32'(count), 3);
    check("R2 not empty", 32'(status[0]), 1);
    check("R4 stopped", 32'(eng_valid), 0);
    eng_busy = 1;
    wctrl(4'b1000);
    check("R4 busy blocks", 32'(eng_valid), 0);
    eng_busy = 0;
    #1;
    check("R4 offered", 32'(eng_valid), 1);
    check("R4 head", eng_data, 32'hA1);
    eng_ready = 1;
    @(negedge clk);
    eng_ready = 0;
    check("R5 pop count", 32'(count), 2);
    check("R4 next", eng_data, 32'hA2);
    eng_ready = 1; cpu_wr_en = 1; cpu_wr_data = 32'hA4;
    @(negedge clk);
    eng_ready = 0; cpu_wr_en = 0;
    check("R5 push+pop count", 32'(count), 2);
    check("R4 order", eng_data, 32'hA3);
    eng_ready = 1;
    @(negedge clk);
    check("R4 order tail", eng_data, 32'hA4);
    @(negedge clk);
    eng_ready = 0;
    check("R5 drained count", 32'(count), 0);
    check("R2 empty", 32'(status[0]), 0);
    check("R4 empty no offer", 32'(eng_valid), 0);
  endtask

  task automatic t_status();
    eng_busy = 1; eng_bus_busy = 1;
    #1;
    check("R9 status", 32'(status), 32'hA);
    eng_busy = 0;
    #1;
    check("R9 busy low", 32'(status), 32'h8);
    eng_bus_busy = 0;
    @(negedge clk);
  endtask

  task automatic t_bump();
    wctrl(4'b0000);
    bump();
    check("R8 bump", 32'(count), 1);
    check("R8 storage untouched", 32'(status[0]), 0);
    stat_rd_inc = 1;
    push(32'hC1);
    stat_rd_inc = 0;
    check("R8 bump+push", 32'(count), 3);
  endtask

  task automatic t_max();
    clear_count();
    check("R6 count cleared", 32'(count), 0);
    check("R6 data kept", 32'(status[0]), 1);
    wlim(16'd3);
    push(32'hB1); push(32'hB2); push(32'hB3);
    check("R3 at max", 32'(status[2]), 1);
    check("R3 no overflow yet", 32'(overflow), 0);
    push(32'hB4);
    check("R3 count held", 32'(count), 3);
    check("R3 overflow", 32'(overflow), 1);
    clear_count();
    check("R6 overflow cleared", 32'(overflow), 0);
    check("R6 count zero", 32'(count), 0);
    wctrl(4'b1000);
    eng_ready = 1;
    check("R4 drain 1", eng_data, 32'hC1);
    @(negedge clk);
    check("R4 drain 2", eng_data, 32'hB1);
    @(negedge clk);
    check("R4 drain 3", eng_data, 32'hB2);
    @(negedge clk);
    check("R4 drain 4", eng_data, 32'hB3);
    @(negedge clk);
    eng_ready = 0;
    check("R3 dropped word absent", 32'(eng_valid), 0);
    check("R10 floor", 32'(count), 0);
    wctrl(4'b0000);
  endtask

  task automatic t_load();
    wcnt(16'h0055);
    check("R7 load ignored", 32'(count), 0);
    wctrl(4'b0100);
    wcnt(16'h0105);
    check("R7 load", 32'(count), 32'h105);
    check("R3 max after load", 32'(status), 32'h4);
    wcnt(16'hFFFF);
    bump();
    check("R10 ceiling", 32'(count), 32'hFFFF);
  endtask

  task automatic t_full();
    clear_count();
    wlim(16'hFFFF);
    for (int i = 0; i < 17; i++) push(32'h100 + 32'(i));
    check("R3 full count", 32'(count), 16);
    check("R3 full overflow", 32'(overflow), 1);
    wctrl(4'b1000);
    eng_ready = 1;
    for (int i = 0; i < 16; i++) begin
      check("R4 full order", eng_data, 32'h100 + 32'(i));
      @(negedge clk);
    end
    eng_ready = 0;
    check("R3 full extra dropped", 32'(eng_valid), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_push_run();
    t_status();
    t_bump();
    t_max();
    t_load();
    t_full();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule